// File: doc/BRIEF.md
# Tear-Check Scan-Line Tracker

This block follows where a command-mode panel is in its refresh, so that a host writing pixels into the panel's own frame memory never overtakes the scan-out. A virtual read pointer counts lines, stepping once every few clock cycles under a programmable divider. In free-running mode it reloads itself after the last line of the frame. In locked mode it holds at the last line until the panel's tearing-effect pulse arrives, and that pulse starts the next frame.

Firmware sets the block up through a small word-addressed register port, with a combinational read path. The block raises a one-cycle interrupt when the read pointer reaches a chosen line. It counts the lines that the upstream pixel source reports as written and raises a second interrupt at a chosen write count. A level output grants permission to start or continue a transfer while the read pointer is inside a window. The block also reports the frame count, the read and write line counts, and the scan position measured from the reload value.

Top module: `tear_sync_counter`

## Requirements
- R1: After reset every register reads zero, `rd_irq`, `wr_irq` and `xfer_ok` are low, and the position register (address 10) reads 0.
- R2: With the enable (address 0, bit 0) and the counter-run bit (address 1, bit 19) set, the read line advances once every DIV clock cycles. DIV is address 1 bits 18:0, and a DIV of 0 acts as 1.
- R3: With bit 20 of address 1 clear, a step taken at line ≥ HEIGHT (address 2, bits 15:0) reloads INIT (address 3, bits 15:0) in place of incrementing, and the frame count increments by one.
- R4: With bit 20 of address 1 set, the line holds once it reaches HEIGHT. A rising edge on `te_in`, after a two-flop synchroniser, reloads INIT and increments the frame count.
- R5: A write to address 11 copies `wdata[0]` into bit 20 of address 1 and leaves its other bits unchanged. Address 11 then reads back, in bit 0, the value bit 20 had before that write.
- R6: `rd_irq` pulses high for exactly the cycles in which the read line has just taken a value equal to TARGET (address 4, bits 15:0).
- R7: Each `line_wr` pulse increments the write line count, which reads at address 9 bits 15:0 and saturates at 0xFFFF. A `frame_start` pulse clears the count. `wr_irq` pulses in the cycle after an increment that makes the count equal WRCNT (address 7, bits 15:0).
- R8: `xfer_ok` is high only while the block is enabled and START ≤ line ≤ START+TS, where START is address 5 and TS is address 6 bits 15:0. Once the write count is nonzero, the upper bound becomes START+TS+TC, where TC is address 6 bits 31:16.
- R9: Address 10 returns line−INIT when line ≥ INIT, and line+(0xFFFF−INIT) when line < INIT. It returns 0xFFFF whenever HEIGHT < INIT.
- R10: While the enable bit is clear, the line is held at INIT, the frame count does not change and `rd_irq` stays low.
- R11: Address 8 returns the frame count in bits 31:16 and the read line in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| te_in | input | 1 | Tearing-effect pulse from the panel (asynchronous) |
| line_wr | input | 1 | One pulse for each line written by the upstream source |
| frame_start | input | 1 | Clears the write line count |
| rd_irq | output | 1 | Read pointer reached TARGET |
| wr_irq | output | 1 | Write count reached WRCNT |
| xfer_ok | output | 1 | Transfer start/continue permitted |

## Verification
The line counter is tried in five setups. A small frame with a divider of 1 shows the wrap and frame-count rule. A divider of 4 checks the step period. A locked-mode frame left without a TE pulse must hold at HEIGHT, and the same frame with a pulse must reload. The case HEIGHT below INIT forces the 0xFFFF position, and a raised INIT under a stalled counter exercises the modular wrap of the position. The transfer window is scanned across a full frame twice: with no line written it follows the start bound, and after one written line it must widen by exactly TC.

// File: rtl/tear_sync_counter.sv
module tear_sync_counter #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int DIVW = 19,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          te_in,
  input  logic          line_wr,
  input  logic          frame_start,
  output logic          rd_irq,
  output logic          wr_irq,
  output logic          xfer_ok
);
  localparam int RUN_B = DIVW;
  localparam int EXT_B = DIVW + 1;
  localparam logic [LW-1:0] LMAX = '1;

  logic          en;
  logic [EXT_B:0] vcfg;
  logic [LW-1:0] height, init, tgt, start, ts, tc, wrcnt;
  logic          te_prev;
  logic [LW-1:0] line, frame, wline;
  logic [DIVW-1:0] dcnt;
  logic [SYNC:0] te_s;

  wire ext    = vcfg[EXT_B];
  wire run    = vcfg[RUN_B];
  wire [DIVW-1:0] div = vcfg[DIVW-1:0];
  wire [DIVW-1:0] div_m1 = (div == '0) ? '0 : div - 1'b1;
  wire te_edge = te_s[SYNC-1] & ~te_s[SYNC];
  wire [LW-1:0] line_inc = line + 1'b1;
  wire [LW-1:0] wline_inc = (wline == LMAX) ? LMAX : wline + 1'b1;

  wire [LW:0]   hi_s = {1'b0, start} + {1'b0, ts};
  wire [LW+1:0] hi_c = {1'b0, hi_s} + {2'b0, tc};
  wire [LW+1:0] hi   = (wline == '0) ? {1'b0, hi_s} : hi_c;
  assign xfer_ok = en && (line >= start) && ({2'b0, line} <= hi);

  logic [LW-1:0] pos;
  always_comb begin
    if (height < init)     pos = LMAX;
    else if (line < init)  pos = line + (LMAX - init);
    else                   pos = line - init;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:  reg_rdata[0] = en;
      4'd1:  reg_rdata[EXT_B:0] = vcfg;
      4'd2:  reg_rdata[LW-1:0] = height;
      4'd3:  reg_rdata[LW-1:0] = init;
      4'd4:  reg_rdata[LW-1:0] = tgt;
      4'd5:  reg_rdata[LW-1:0] = start;
      4'd6:  reg_rdata = {tc, ts};
      4'd7:  reg_rdata[LW-1:0] = wrcnt;
      4'd8:  reg_rdata = {frame, line};
      4'd9:  reg_rdata[LW-1:0] = wline;
      4'd10: reg_rdata[LW-1:0] = pos;
      4'd11: reg_rdata[0] = te_prev;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; vcfg <= '0; height <= '0; init <= '0; tgt <= '0;
      start <= '0; ts <= '0; tc <= '0; wrcnt <= '0; te_prev <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0:  en <= reg_wdata[0];
        4'd1:  vcfg <= reg_wdata[EXT_B:0];
        4'd2:  height <= reg_wdata[LW-1:0];
        4'd3:  init <= reg_wdata[LW-1:0];
        4'd4:  tgt <= reg_wdata[LW-1:0];
        4'd5:  start <= reg_wdata[LW-1:0];
        4'd6:  begin ts <= reg_wdata[LW-1:0]; tc <= reg_wdata[DW-1:LW]; end
        4'd7:  wrcnt <= reg_wdata[LW-1:0];
        4'd11: begin te_prev <= vcfg[EXT_B]; vcfg[EXT_B] <= reg_wdata[0]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_s <= '0; line <= '0; frame <= '0; dcnt <= '0; rd_irq <= 1'b0;
    end else begin
      te_s <= {te_s[SYNC-1:0], te_in};
      rd_irq <= 1'b0;
      if (!en) begin
        line <= init;
        dcnt <= '0;
      end else if (ext && te_edge) begin
        line <= init;
        frame <= frame + 1'b1;
        dcnt <= '0;
        rd_irq <= (init == tgt);
      end else if (run) begin
        if (dcnt >= div_m1) begin
          dcnt <= '0;
          if (line >= height) begin
            if (!ext) begin
              line <= init;
              frame <= frame + 1'b1;
              rd_irq <= (init == tgt);
            end
          end else begin
            line <= line_inc;
            rd_irq <= (line_inc == tgt);
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wline <= '0; wr_irq <= 1'b0;
    end else begin
      wr_irq <= 1'b0;
      if (frame_start) begin
        wline <= '0;
      end else if (line_wr) begin
        wline <= wline_inc;
        wr_irq <= (wline_inc == wrcnt);
      end
    end
  end

  // R6
  rd_irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_irq |-> (line == tgt));
  // R7
  wr_irq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq |-> (wline == wrcnt));
  // R8
  xfer_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |-> en);
  // R3
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && !$stable(frame)) |-> (frame == $past(frame) + 1'b1));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (line == $past(init)) && !rd_irq);
endmodule

// File: tb/tear_sync_counter_tb.sv
`timescale 1ns/1ps
module tear_sync_counter_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, te_in = 0, line_wr = 0, frame_start = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic rd_irq, wr_irq, xfer_ok;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tear_sync_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .te_in(te_in),
    .line_wr(line_wr), .frame_start(frame_start), .rd_irq(rd_irq),
    .wr_irq(wr_irq), .xfer_ok(xfer_ok));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 4'd8;
  endtask

  task automatic rreg(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata; reg_addr = 4'd8;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(logic [31:0] vc, logic [15:0] h, logic [15:0] ini);
    wreg(0, 0); wreg(1, vc); wreg(2, h); wreg(3, ini); cycles(2);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int bad = 0;
    for (int a = 0; a < 12; a++) begin rreg(a[3:0], d); if (d != 0) bad++; end
    check("R1 regs zero", bad, 0);
    check("R1 outputs idle", {rd_irq, wr_irq, xfer_ok}, 0);
    rreg(10, d); check("R1 position", d, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] d, p;
    int bad = 0, irqs = 0, bad_irq = 0;
    setup(32'h0008_0001, 3, 1); wreg(4, 2); wreg(0, 1);
    cycles(2);
    rreg(8, p);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); rreg(8, d);
      if (d[15:0] != ((p[15:0] == 3) ? 16'd1 : p[15:0] + 16'd1)) bad++;
      if (d[31:16] != ((p[15:0] == 3) ? p[31:16] + 16'd1 : p[31:16])) bad++;
      if (rd_irq) begin irqs++; if (d[15:0] != 2) bad_irq++; end
      p = d;
    end
    check("R3 wrap and frame count", bad, 0);
    check("R11 status packing frame nonzero", (p[31:16] >= 2), 1);
    check("R6 irq count", irqs, 3);
    check("R6 irq line", bad_irq, 0);
  endtask

  task automatic t_div;
    logic [31:0] d, p;
    int n = 0;
    setup(32'h0008_0004, 200, 0); wreg(0, 1);
    rreg(8, p);
    for (int i = 0; i < 20; i++) begin @(negedge clk); rreg(8, d); if (d != p) break; end
    p = d;
    for (int i = 0; i < 20; i++) begin @(negedge clk); n++; rreg(8, d); if (d != p) break; end
    check("R2 step period", n, 4);
  endtask

  task automatic t_ext;
    logic [31:0] d, f0;
    int found = 0;
    setup(32'h0018_0001, 8, 5); wreg(0, 1);
    cycles(15); rreg(8, d);
    check("R4 hold at height", d[15:0], 8);
    f0 = d;
    cycles(5); rreg(8, d);
    check("R4 no self reload", d, f0);
    @(negedge clk); te_in = 1; cycles(3); te_in = 0;
    for (int i = 0; i < 10; i++) begin
      rreg(8, d); if (d[15:0] == 5) begin found = 1; break; end
      @(negedge clk);
    end
    check("R4 TE reload", found, 1);
    check("R4 TE frame step", d[31:16], f0[31:16] + 1);
  endtask

  task automatic t_tesel;
    logic [31:0] d;
    setup(32'h0008_0007, 8, 0);
    wreg(11, 1); rreg(1, d); check("R5 set keeps others", d, 32'h0018_0007);
    rreg(11, d); check("R5 old value 0", d, 0);
    wreg(11, 0); rreg(1, d); check("R5 clear keeps others", d, 32'h0008_0007);
    rreg(11, d); check("R5 old value 1", d, 1);
  endtask

  task automatic t_wr;
    logic [31:0] d;
    int irqs = 0;
    wreg(7, 3);
    @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
    for (int i = 0; i < 4; i++) begin
      line_wr = 1; @(negedge clk); line_wr = 0;
      if (wr_irq) begin irqs++; rreg(9, d); check("R7 irq at count", d, 3); end
      @(negedge clk); if (wr_irq) irqs++;
    end
    check("R7 one irq", irqs, 1);
    rreg(9, d); check("R7 count", d, 4);
    @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
    rreg(9, d); check("R7 clear", d, 0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    int bad0 = 0, bad1 = 0, hits = 0;
    logic exp;
    setup(32'h0008_0001, 20, 0);
    wreg(5, 10); wreg(6, {16'd3, 16'd2}); wreg(0, 1);
    for (int i = 0; i < 44; i++) begin
      @(negedge clk); rreg(8, d);
      exp = (d[15:0] >= 10) && (d[15:0] <= 12);
      if (xfer_ok !== exp) bad0++;
      if (exp) hits++;
    end
    check("R8 start window", bad0, 0);
    check("R8 window seen", hits > 0, 1);
    line_wr = 1; @(negedge clk); line_wr = 0;
    for (int i = 0; i < 44; i++) begin
      @(negedge clk); rreg(8, d);
      exp = (d[15:0] >= 10) && (d[15:0] <= 15);
      if (xfer_ok !== exp) bad1++;
    end
    check("R8 continue window", bad1, 0);
  endtask

  task automatic t_pos;
    logic [31:0] d, p;
    int bad = 0;
    setup(32'h0008_0001, 8, 5); wreg(0, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rreg(8, d); rreg(10, p);
      if (p != d[15:0] - 5) bad++;
    end
    check("R9 offset position", bad, 0);
    wreg(3, 9); cycles(2); rreg(10, p);
    check("R9 height below init", p, 32'h0000_FFFF);
    setup(32'h0008_03E8, 100, 0); wreg(0, 1); wreg(3, 3);
    rreg(10, p); check("R9 modular wrap", p, 32'h0000_FFFC);
  endtask

  task automatic t_off;
    logic [31:0] d, f0;
    int irqs = 0, ok = 0;
    setup(32'h0008_0001, 10, 4); wreg(4, 4); wreg(5, 0); wreg(6, 32'h00FF_00FF);
    rreg(8, f0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (rd_irq) irqs++; if (xfer_ok) ok++;
    end
    rreg(8, d);
    check("R10 hold line and frame", d, f0);
    check("R10 line at init", d[15:0], 4);
    check("R10 no irq or permit", irqs + ok, 0);
  endtask

  initial begin
    #(8ns * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cycles(3); rst_n = 1; reg_addr = 4'd8; @(negedge clk);
    t_reset;
    t_wrap;
    t_div;
    t_ext;
    t_tesel;
    t_wr;
    t_window;
    t_pos;
    t_off;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule